// File: doc/BRIEF.md
# Bidirectional latch/register bus transceiver

This block carries a multi-bit word between two ports, A and B, with an independent storage path for each direction. For each bit and direction there is one storage element, and three modes select what it does. With its latch enable high it is transparent and passes the source port to the far port. With the latch enable low and the strobe steady it holds its value. With the latch enable low, a rising strobe captures the source word.

Each destination port is modelled as a data vector plus a per-bit drive-enable vector, in place of a real tri-state pad. The A-to-B enable is active high. The B-to-A enable is active low. An optional keeper on each source port remembers the last driven level of every bit. The keeper supplies that level while the external driver of the bit is released.

The whole block runs on one system clock, with a synchronous active-high reset. The direction strobes and latch enables are sampled on that clock. Every output comes straight from a register and lags its inputs by one system clock.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: One clock after reset is released, with all inputs low and `oe_ba_n` high, `a_out` and `b_out` read zero and `a_oe` and `b_oe` read all zeros.
- R2: While `le_ab` is 1, `b_out` equals the effective A word sampled one system clock earlier.
- R3: While `le_ab` is 0 and `stb_ab` holds a constant level (either 0 or 1), `b_out` does not change, whatever the A word does.
- R4: While `le_ab` is 0, a 0-to-1 change of `stb_ab` between two consecutive system clocks stores the effective A word of the second of those clocks, and it appears on `b_out` one clock later.
- R5: When `le_ab` falls while `stb_ab` is 1, the last word passed through is kept. A later fall of `stb_ab` does not change it. The next rise of `stb_ab` loads a new word.
- R6: `b_oe` is all ones one clock after `oe_ab` is 1, and all zeros one clock after it is 0. This holds regardless of the data, latch enable and strobe inputs.
- R7: `a_oe` is all ones one clock after `oe_ba_n` is 0, and all zeros one clock after it is 1.
- R8: The B-to-A path behaves as in R2 to R5, using `le_ba`, `stb_ba` and the B word as source, and `a_out` as destination.
- R9: Activity on the controls and data of one direction never changes the word stored in the other direction.
- R10: With the keeper enabled, a source bit whose drive flag (`a_drv` or `b_drv`) is 0 takes the level it had the last time its flag was 1, or zero if it has not been driven since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Level seen on the A port pins |
| a_drv | input | WIDTH | Per-bit flag: an external driver is active on the A port |
| a_out | output | WIDTH | Word the B-to-A path drives onto the A port |
| a_oe | output | WIDTH | Per-bit drive enable for the A port |
| b_in | input | WIDTH | Level seen on the B port pins |
| b_drv | input | WIDTH | Per-bit flag: an external driver is active on the B port |
| b_out | output | WIDTH | Word the A-to-B path drives onto the B port |
| b_oe | output | WIDTH | Per-bit drive enable for the B port |
| oe_ab | input | 1 | B port drive enable, active high |
| le_ab | input | 1 | A-to-B latch enable (1 = transparent) |
| stb_ab | input | 1 | A-to-B capture strobe, rising edge stores |
| oe_ba_n | input | 1 | A port drive enable, active low |
| le_ba | input | 1 | B-to-A latch enable (1 = transparent) |
| stb_ba | input | 1 | B-to-A capture strobe, rising edge stores |

## Verification
Transparent mode is swept with a run of arithmetically spread words, so a stuck or swapped bit shows up as a mismatch. Holding is tried with the strobe parked low and parked high while the source keeps changing. This separates a true hold from a level-sensitive capture. The falling-enable-with-strobe-high sequence separates edge capture from capture on either strobe edge. Toggling one path while the other sits in hold shows any coupling between directions, and mixed drive masks show whether the keeper merges driven and remembered bits per bit.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    MODE_FLOW  = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_CLOCK = 2'd2
  } cell_mode_e;

  // Latch enable wins over the strobe; without either the cell keeps its word.
  function automatic cell_mode_e pick_mode(input logic le, input logic rise);
    if (le)
      return MODE_FLOW;
    else if (rise)
      return MODE_CLOCK;
    else
      return MODE_HOLD;
  endfunction

endpackage

// File: rtl/bus_keeper.sv
module bus_keeper #(
  parameter int W    = 18,
  parameter bit KEEP = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] drv,
  output logic [W-1:0] level
);

  generate
    if (KEEP) begin : g_keep
      logic [W-1:0] keep_q;

      assign level = (pin & drv) | (keep_q & ~drv);

      always_ff @(posedge clk) begin
        if (rst)
          keep_q <= '0;
        else
          keep_q <= level;
      end

      // R10: an undriven bit keeps its remembered level
      p_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (drv == '0) |=> (keep_q == $past(keep_q)));
    end else begin : g_pass
      assign level = pin;
    end
  endgenerate

endmodule

// File: rtl/xfer_cell.sv
module xfer_cell
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic         stb,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  logic       stb_q;
  logic       rise;
  cell_mode_e mode;

  // Previous strobe level; follows the pin even in reset so no false edge
  always_ff @(posedge clk) begin
    stb_q <= stb;
  end

  assign rise = stb & ~stb_q;

  always_comb begin
    mode = pick_mode(le, rise);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (mode)
        MODE_FLOW, MODE_CLOCK: q <= din;
        default:               q <= q;
      endcase
    end
  end

  // R2: transparent while latch enable is high
  p_follow_r2: assert property (@(posedge clk) disable iff (rst)
    le |=> (q == $past(din)));

  // R3: steady strobe with latch enable low leaves the word alone
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!le && (stb == stb_q)) |=> $stable(q));

  // R4: rising strobe stores the source
  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (!le && stb && !stb_q) |=> (q == $past(din)));

endmodule

// File: rtl/oe_stage.sv
module oe_stage #(
  parameter int W          = 18,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] oe
);

  logic asserted;

  generate
    if (ACTIVE_LOW) begin : g_low
      assign asserted = ~en;
      // R7: active-low enable, one clock of latency
      p_oe_low_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (oe == {W{!$past(en)}}));
    end else begin : g_high
      assign asserted = en;
      // R6: active-high enable, one clock of latency
      p_oe_high_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (oe == {W{$past(en)}}));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      oe <= '0;
    else
      oe <= {W{asserted}};
  end

endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr #(
  parameter int WIDTH = 18,
  parameter bit KEEP  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] a_drv,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] b_drv,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe,
  input  logic             oe_ab,
  input  logic             le_ab,
  input  logic             stb_ab,
  input  logic             oe_ba_n,
  input  logic             le_ba,
  input  logic             stb_ba
);

  localparam int NDIR = 2;  // index 0: A to B, index 1: B to A

  logic [NDIR-1:0][WIDTH-1:0] src_pin, src_drv, src_lvl, dst_q;
  logic [NDIR-1:0]            dir_le, dir_stb;

  assign src_pin[0] = a_in;
  assign src_drv[0] = a_drv;
  assign dir_le[0]  = le_ab;
  assign dir_stb[0] = stb_ab;
  assign src_pin[1] = b_in;
  assign src_drv[1] = b_drv;
  assign dir_le[1]  = le_ba;
  assign dir_stb[1] = stb_ba;

  generate
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
      bus_keeper #(.W(WIDTH), .KEEP(KEEP)) u_keep (
        .clk  (clk),
        .rst  (rst),
        .pin  (src_pin[d]),
        .drv  (src_drv[d]),
        .level(src_lvl[d])
      );

      xfer_cell #(.W(WIDTH)) u_cell (
        .clk(clk),
        .rst(rst),
        .le (dir_le[d]),
        .stb(dir_stb[d]),
        .din(src_lvl[d]),
        .q  (dst_q[d])
      );
    end
  endgenerate

  assign b_out = dst_q[0];
  assign a_out = dst_q[1];

  oe_stage #(.W(WIDTH), .ACTIVE_LOW(1'b0)) u_oe_b (
    .clk(clk),
    .rst(rst),
    .en (oe_ab),
    .oe (b_oe)
  );

  oe_stage #(.W(WIDTH), .ACTIVE_LOW(1'b1)) u_oe_a (
    .clk(clk),
    .rst(rst),
    .en (oe_ba_n),
    .oe (a_oe)
  );

endmodule

// File: tb/tb_bidir_reg_xcvr.sv
module tb_bidir_reg_xcvr;

  localparam int W      = 18;
  localparam int CLK_NS = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, a_drv, b_in, b_drv;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic         oe_ab, le_ab, stb_ab, oe_ba_n, le_ba, stb_ba;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  logic [W-1:0] p, q, r, m, keep_a;

  always #(CLK_NS/2) clk = ~clk;

  bidir_reg_xcvr #(.WIDTH(W), .KEEP(1'b1)) dut (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_drv(a_drv), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_drv(b_drv), .b_out(b_out), .b_oe(b_oe),
    .oe_ab(oe_ab), .le_ab(le_ab), .stb_ab(stb_ab),
    .oe_ba_n(oe_ba_n), .le_ba(le_ba), .stb_ba(stb_ba)
  );

  function automatic logic [W-1:0] pat(input int i);
    logic [31:0] v;
    v = (i * 32'h0001_6A5B) ^ 32'h0002_C71D ^ (i << 7);
    return v[W-1:0];
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; a_in = '0; b_in = '0; a_drv = '1; b_drv = '1;
    oe_ab = 1'b0; le_ab = 1'b0; stb_ab = 1'b0;
    oe_ba_n = 1'b1; le_ba = 1'b0; stb_ba = 1'b0;
    step(); step(); step();
    rst = 1'b0;
    step();
    chk("R1 a_out", a_out, '0);
    chk("R1 b_out", b_out, '0);
    chk("R1 a_oe", a_oe, '0);
    chk("R1 b_oe", b_oe, '0);

    // R2 transparent A to B, B path untouched (R9)
    le_ab = 1'b1;
    for (int i = 0; i < 24; i++) begin
      a_in = pat(i);
      step();
      chk("R2 b_out follows a", b_out, pat(i));
      chk("R9 a_out unchanged", a_out, '0);
    end
    p = pat(23);

    // R3 hold with strobe parked low
    le_ab = 1'b0;
    for (int i = 0; i < 8; i++) begin
      a_in = pat(100 + i);
      step();
      chk("R3 hold strobe low", b_out, p);
    end

    // R4 capture sweep; each rise stores, then R3 with strobe parked high
    for (int i = 0; i < 16; i++) begin
      stb_ab = 1'b0; a_in = ~pat(200 + i);
      step();
      chk("R3 hold before rise", b_out, (i == 0) ? p : pat(199 + i));
      stb_ab = 1'b1; a_in = pat(200 + i);
      step();
      chk("R4 rise captures", b_out, pat(200 + i));
      a_in = ~pat(300 + i);
      step();
      chk("R3 hold strobe high", b_out, pat(200 + i));
    end

    // R5 latch enable falls while strobe high
    p = pat(400); q = pat(401); r = pat(402);
    le_ab = 1'b1; stb_ab = 1'b1; a_in = p;
    step();
    chk("R5 flow before fall", b_out, p);
    le_ab = 1'b0; a_in = q;
    step();
    chk("R5 kept after enable fall", b_out, p);
    stb_ab = 1'b0; a_in = r;
    step();
    chk("R5 strobe fall ignored", b_out, p);
    stb_ab = 1'b1;
    step();
    chk("R5 next rise loads", b_out, r);

    // R6 B drive enable, independent of latch activity
    oe_ab = 1'b1;
    step();
    chk("R6 b_oe on", b_oe, '1);
    oe_ab = 1'b0; le_ab = 1'b1; stb_ab = 1'b0;
    step();
    chk("R6 b_oe off", b_oe, '0);
    stb_ab = 1'b1; a_in = pat(410);
    step();
    chk("R6 b_oe stays off", b_oe, '0);

    // R7 A drive enable, active low
    oe_ba_n = 1'b0;
    step();
    chk("R7 a_oe on", a_oe, '1);
    oe_ba_n = 1'b1;
    step();
    chk("R7 a_oe off", a_oe, '0);

    // Park A path holding a known word
    le_ab = 1'b1; stb_ab = 1'b0; a_in = pat(500);
    step();
    le_ab = 1'b0;
    step();
    chk("R3 parked a to b", b_out, pat(500));

    // R8 B to A transparent, while A path holds (R9)
    le_ba = 1'b1;
    for (int i = 0; i < 16; i++) begin
      b_in = pat(600 + i);
      step();
      chk("R8 a_out follows b", a_out, pat(600 + i));
      chk("R9 b_out unchanged", b_out, pat(500));
    end
    le_ba = 1'b0;
    b_in = pat(700);
    step();
    chk("R8 hold strobe low", a_out, pat(615));
    stb_ba = 1'b1;
    step();
    chk("R8 rise captures", a_out, pat(700));
    b_in = pat(701);
    step();
    chk("R8 hold strobe high", a_out, pat(700));
    // R8 enable fall with strobe high
    le_ba = 1'b1; b_in = pat(702);
    step();
    le_ba = 1'b0; b_in = pat(703);
    step();
    chk("R8 kept after enable fall", a_out, pat(702));
    stb_ba = 1'b0;
    step();
    stb_ba = 1'b1;
    step();
    chk("R8 next rise loads", a_out, pat(703));

    // R9 A path churn must not disturb B to A word
    for (int i = 0; i < 12; i++) begin
      le_ab = i[0]; stb_ab = i[1]; oe_ab = i[2]; a_in = pat(800 + i);
      step();
      chk("R9 a_out isolated", a_out, pat(703));
    end

    // R10 keeper on the A source
    le_ab = 1'b1; a_drv = '1; p = pat(900); a_in = p;
    step();
    chk("R10 driven word", b_out, p);
    a_drv = '0; a_in = ~p;
    step();
    chk("R10 all undriven", b_out, p);
    m = pat(901); q = pat(902); a_drv = m; a_in = q;
    step();
    keep_a = (q & m) | (p & ~m);
    chk("R10 mixed mask", b_out, keep_a);
    a_drv = '0; a_in = pat(903);
    step();
    chk("R10 remembered mix", b_out, keep_a);
    // R10 keeper on the B source
    le_ba = 1'b1; b_drv = '0; b_in = pat(904);
    step();
    chk("R10 b keeper", a_out, pat(703));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule